// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block picks one DMA channel to serve when several channels raise requests in the same cycle. Two controllers feed it: controller A has seven channels and controller B has five. Each channel gives a request bit, an enable bit and a two-bit priority level that software sets. The arbiter registers its decision as a one-hot grant, together with the controller and the channel index of the winner.

The grant stays in place until the served channel reports that its beat is done. A single winner is chosen among the enabled requesting channels. Controller A wins over controller B whenever A has any eligible request. Inside a controller the highest level wins, and the lower channel number breaks a tie. The grant then drops for one cycle and the next decision is made at the following edge.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, grant_a and grant_b are zero and grant_valid is low.
- R2: Within a controller, the eligible channel whose priority field is numerically largest wins. The field of channel i is bits [2i+1:2i] of its controller's priority port, and 2'b11 is the highest level while 2'b00 is the lowest.
- R3: Among eligible channels of one controller at equal level, the lowest channel number wins.
- R4: When controller A has any eligible request at a decision edge, an A channel is granted whatever the levels on controller B. grant_ctrl is 0 for A and 1 for B.
- R5: A channel takes part only when both its request and its enable bit are 1. A request on a disabled channel never gets a grant.
- R6: Once granted, grant_a, grant_b, grant_ctrl and grant_idx hold until beat_done is sampled high at an edge. After that edge grant_valid is low for one cycle, and the next decision is made at the following edge.
- R7: With no eligible request at a decision edge, the grant vectors stay all zero and grant_valid stays low. A beat_done pulse while idle has no effect.
- R8: At most one bit of {grant_b, grant_a} is set, and grant_valid equals the OR of those bits. grant_idx is the position of the set bit.
- R9: Priority fields are used only at a decision edge. Changing them, or raising new requests, while a grant is held does not alter that grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | CH_A | Request bits, controller A |
| a_en | input | CH_A | Channel enable bits, controller A |
| a_prio | input | CH_A*LW | Packed priority levels, controller A |
| b_req | input | CH_B | Request bits, controller B |
| b_en | input | CH_B | Channel enable bits, controller B |
| b_prio | input | CH_B*LW | Packed priority levels, controller B |
| beat_done | input | 1 | The granted channel has finished its beat |
| grant_a | output | CH_A | One-hot grant, controller A |
| grant_b | output | CH_B | One-hot grant, controller B |
| grant_valid | output | 1 | A grant is held |
| grant_ctrl | output | 1 | Controller of the winner (0 = A, 1 = B) |
| grant_idx | output | IW | Channel index of the winner |

## Verification
The directed patterns each target one rule:
- Two A channels at different levels show whether the level comparison is used at all.
- Equal levels show the direction of the tie-break.
- A low-level A request against a top-level B request separates the fixed controller order from a global level comparison.
- A disabled channel at top level shows whether the enable is honoured.
- Changing levels and adding requests during a held grant shows whether the decision was latched.

A long random phase then drives requests, enables, levels and beat_done freely. A behavioural model, which scans levels from high to low, is compared with every output on each clock.

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int CH_A = 7,
  parameter int CH_B = 5,
  parameter int LW   = 2,
  localparam int IW  = (CH_A > CH_B) ? $clog2(CH_A) : $clog2(CH_B)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CH_A-1:0]    a_req,
  input  logic [CH_A-1:0]    a_en,
  input  logic [CH_A*LW-1:0] a_prio,
  input  logic [CH_B-1:0]    b_req,
  input  logic [CH_B-1:0]    b_en,
  input  logic [CH_B*LW-1:0] b_prio,
  input  logic               beat_done,
  output logic [CH_A-1:0]    grant_a,
  output logic [CH_B-1:0]    grant_b,
  output logic               grant_valid,
  output logic               grant_ctrl,
  output logic [IW-1:0]      grant_idx
);

  logic          a_hit, b_hit;
  logic [LW-1:0] a_lvl, b_lvl;
  logic [IW-1:0] a_win, b_win;

  always_comb begin
    a_hit = 1'b0;
    a_lvl = '0;
    a_win = '0;
    for (int i = 0; i < CH_A; i++) begin
      if (a_req[i] && a_en[i] && (!a_hit || a_prio[i*LW +: LW] > a_lvl)) begin
        a_hit = 1'b1;
        a_lvl = a_prio[i*LW +: LW];
        a_win = IW'(i);
      end
    end
  end

  always_comb begin
    b_hit = 1'b0;
    b_lvl = '0;
    b_win = '0;
    for (int i = 0; i < CH_B; i++) begin
      if (b_req[i] && b_en[i] && (!b_hit || b_prio[i*LW +: LW] > b_lvl)) begin
        b_hit = 1'b1;
        b_lvl = b_prio[i*LW +: LW];
        b_win = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_a     <= '0;
      grant_b     <= '0;
      grant_ctrl  <= 1'b0;
      grant_idx   <= '0;
    end else if (!grant_valid) begin
      if (a_hit) begin
        grant_valid <= 1'b1;
        grant_a     <= {{(CH_A-1){1'b0}}, 1'b1} << a_win;
        grant_b     <= '0;
        grant_ctrl  <= 1'b0;
        grant_idx   <= a_win;
      end else if (b_hit) begin
        grant_valid <= 1'b1;
        grant_a     <= '0;
        grant_b     <= {{(CH_B-1){1'b0}}, 1'b1} << b_win;
        grant_ctrl  <= 1'b1;
        grant_idx   <= b_win;
      end
    end else if (beat_done) begin
      grant_valid <= 1'b0;
      grant_a     <= '0;
      grant_b     <= '0;
      grant_ctrl  <= 1'b0;
      grant_idx   <= '0;
    end
  end

endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
  parameter int CH_A = 7,
  parameter int CH_B = 5,
  parameter int LW   = 2,
  localparam int IW  = (CH_A > CH_B) ? $clog2(CH_A) : $clog2(CH_B)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CH_A-1:0] a_req,
  input logic [CH_A-1:0] a_en,
  input logic [CH_B-1:0] b_req,
  input logic [CH_B-1:0] b_en,
  input logic            beat_done,
  input logic [CH_A-1:0] grant_a,
  input logic [CH_B-1:0] grant_b,
  input logic            grant_valid,
  input logic            grant_ctrl,
  input logic [IW-1:0]   grant_idx
);

  // R8
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_b, grant_a}));

  // R8
  valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == |{grant_b, grant_a});

  // R8
  idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_ctrl ? grant_b[grant_idx] : grant_a[grant_idx]));

  // R6
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !beat_done |=> grant_valid && $stable(grant_a) && $stable(grant_b) && $stable(grant_idx));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && beat_done |=> !grant_valid);

  // R4
  ctrl_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) && grant_ctrl |-> $past((a_req & a_en) == '0));

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(grant_valid) && $past(((a_req & a_en) == '0) && ((b_req & b_en) == '0)) |-> !grant_valid);

  for (genvar i = 0; i < CH_A; i++) begin : g_a
    // R5
    a_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_a[i]) |-> $past(a_req[i] && a_en[i]));
  end

  for (genvar i = 0; i < CH_B; i++) begin : g_b
    // R5
    b_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_b[i]) |-> $past(b_req[i] && b_en[i]));
  end

endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.CH_A(CH_A), .CH_B(CH_B), .LW(LW)) u_chk (.*);

// File: tb/dma_prio_arbiter_test.sv
module dma_prio_arbiter_test;
  localparam int CH_A = 7;
  localparam int CH_B = 5;
  localparam int LW   = 2;
  localparam int IW   = 3;

  logic clk = 1'b0, rst_n = 1'b0, beat_done = 1'b0;
  logic [CH_A-1:0] a_req = '0, a_en = '0;
  logic [CH_B-1:0] b_req = '0, b_en = '0;
  logic [CH_A*LW-1:0] a_prio = '0;
  logic [CH_B*LW-1:0] b_prio = '0;
  logic [CH_A-1:0] grant_a;
  logic [CH_B-1:0] grant_b;
  logic grant_valid, grant_ctrl;
  logic [IW-1:0] grant_idx;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  logic e_valid = 1'b0, e_ctrl = 1'b0;
  int e_idx = 0;

  always #2 clk = ~clk;

  dma_prio_arbiter uut (.*);

  // behavioural reference: scan levels from high to low, channels ascending
  always @(posedge clk) begin
    bit found;
    if (!rst_n) begin
      e_valid = 1'b0; e_ctrl = 1'b0; e_idx = 0;
    end else if (!e_valid) begin
      found = 0;
      for (int lv = 3; lv >= 0 && !found; lv--)
        for (int c = 0; c < CH_A && !found; c++)
          if (a_req[c] && a_en[c] && int'(a_prio[c*LW +: LW]) == lv) begin
            found = 1; e_ctrl = 1'b0; e_idx = c;
          end
      for (int lv = 3; lv >= 0 && !found; lv--)
        for (int c = 0; c < CH_B && !found; c++)
          if (b_req[c] && b_en[c] && int'(b_prio[c*LW +: LW]) == lv) begin
            found = 1; e_ctrl = 1'b1; e_idx = c;
          end
      e_valid = found;
    end else if (beat_done) begin
      e_valid = 1'b0; e_ctrl = 1'b0; e_idx = 0;
    end
  end

  function automatic bit [CH_A+CH_B-1:0] exp_vec();
    bit [CH_A+CH_B-1:0] v = '0;
    if (e_valid) v[e_ctrl ? CH_A + e_idx : e_idx] = 1'b1;
    return v;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    checks++;
    if ({grant_b, grant_a} !== exp_vec() || grant_valid !== e_valid ||
        (e_valid && (grant_ctrl !== e_ctrl || int'(grant_idx) != e_idx))) begin
      errors++;
      $display("FAIL %s: got valid=%b ctrl=%b idx=%0d vec=%b, expected valid=%b ctrl=%b idx=%0d vec=%b",
               tag, grant_valid, grant_ctrl, grant_idx, {grant_b, grant_a},
               e_valid, e_ctrl, e_idx, exp_vec());
    end
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected at most 20000", cycles);
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chan_a(int c, int lv, bit en, bit rq);
    a_prio[c*LW +: LW] = LW'(lv); a_en[c] = en; a_req[c] = rq;
  endtask

  task automatic chan_b(int c, int lv, bit en, bit rq);
    b_prio[c*LW +: LW] = LW'(lv); b_en[c] = en; b_req[c] = rq;
  endtask

  task automatic clear_all();
    a_req = '0; a_en = '0; a_prio = '0; b_req = '0; b_en = '0; b_prio = '0;
  endtask

  task automatic finish_beat();
    beat_done = 1'b1; step(1); beat_done = 1'b0; clear_all(); step(2);
  endtask

  initial begin
    tag = "R1"; step(3); rst_n = 1'b1; step(1);
    tag = "R7"; step(2); beat_done = 1'b1; step(1); beat_done = 1'b0; step(2);
    tag = "R2"; chan_a(2, 1, 1, 1); chan_a(5, 3, 1, 1); step(3); finish_beat();
    tag = "R3"; chan_a(1, 2, 1, 1); chan_a(4, 2, 1, 1); step(2); finish_beat();
    tag = "R3"; chan_b(3, 2, 1, 1); chan_b(1, 2, 1, 1); step(2); finish_beat();
    tag = "R4"; chan_a(6, 0, 1, 1); chan_b(0, 3, 1, 1); step(2); finish_beat();
    tag = "R5"; chan_a(0, 3, 0, 1); chan_a(3, 0, 1, 1); step(2); finish_beat();
    tag = "R5"; chan_a(0, 3, 0, 1); chan_b(4, 1, 0, 1); step(3);
    tag = "R9"; chan_b(2, 0, 1, 1); step(2);
    chan_b(2, 3, 1, 1); chan_a(1, 3, 1, 1); step(3);
    tag = "R6"; beat_done = 1'b1; step(1); beat_done = 1'b0; step(3); finish_beat();
    tag = "R6";
    for (int c = 0; c < CH_A; c++) chan_a(c, c % 4, 1, 1);
    for (int k = 0; k < 6; k++) begin
      step(1); beat_done = 1'b1; step(1); beat_done = 1'b0; step(1);
      a_req[3 + (k % 4)] = 1'b0;
    end
    clear_all(); step(2);
    tag = "R8";
    for (int k = 0; k < 3000; k++) begin
      a_req = CH_A'($urandom); a_en = CH_A'($urandom | $urandom);
      b_req = CH_B'($urandom); b_en = CH_B'($urandom | $urandom);
      a_prio = (CH_A*LW)'($urandom); b_prio = (CH_B*LW)'($urandom);
      beat_done = ($urandom % 3) == 0;
      step(1);
    end
    beat_done = 1'b0; clear_all(); step(2);
    tag = "R1"; rst_n = 1'b0; chan_a(2, 3, 1, 1); step(2); rst_n = 1'b1; step(2);
    finish_run();
  end
endmodule